// File: doc/BRIEF.md
# Duty-Cycled Receiver Wake Sequencer

This block runs the periodic low-power listen cycle of a radio receiver. While enabled it repeats four phases. In the sleep phase it counts a programmable off interval with every controlled power domain switched off. In the host-wake phase it pulls an open-drain host signalling line low and waits a programmable recovery time, so that the host processor can power up. In the settle phase it switches on the RF power domains chosen in a mask register and waits a programmable settling time. In the listen phase it raises a receive-window flag for a programmable on time. At the end of listen it releases the host line and goes back to sleep.

All timing derives from a base unit of `BASE_DIV` system clocks, which is 120 µs at the intended clock. A two-bit select stretches the sleep unit to 1, 4, 16 or 64 base units; the largest gives 7.68 ms per count. The interval counts are loaded from byte-wide registers through a simple write port. A zero count in any of them stops the cycle from starting and flags a configuration error. Clearing the enable bit abandons the cycle from any phase.

Top module: `drx_wake_seq`

## Requirements
- R1: After reset all configuration registers are zero, the block is idle, `host_pull` is 0, `rx_window` is 0, `cfg_err` is 0 and `pwr_en` is 0.
- R2: Register addresses: 0x0 power mask, 0x1 control (bit 0 enable, bits 2:1 sleep-unit select), 0x6 sleep count high byte, 0x7 sleep count low byte, 0x8 host recovery count, 0x9 settle count high byte, 0xA settle count low byte, 0xB listen count. A write takes effect at the clock edge on which `wr_en` is high.
- R3: Sleep lasts exactly off_count × BASE_DIV × 4^sel clocks, for sel = 0..3. During sleep `pwr_en` is 0 and `host_pull` is 0.
- R4: Host-wake follows sleep directly and lasts host_count × BASE_DIV clocks, with `host_pull` = 1 and `pwr_en` = 0.
- R5: Settle follows host-wake and lasts settle_count × BASE_DIV clocks, where settle_count is the 16-bit value {0x9, 0xA}. During settle `pwr_en` equals the power mask, `host_pull` = 1 and `rx_window` = 0.
- R6: Listen follows settle and lasts listen_count × BASE_DIV clocks, with `rx_window` = 1, `host_pull` = 1 and `pwr_en` equal to the mask. Sleep follows listen, with `host_pull` released.
- R7: If enable is set while the sleep, host, settle or listen count is zero, the cycle does not start and `cfg_err` rises one clock after the enable is registered. The block then stays idle until enable is cleared, which clears `cfg_err` one clock later.
- R8: One clock after enable is registered as 0, the block is idle whatever its phase: `host_pull` = 0, `rx_window` = 0 and `pwr_en` equals the mask.
- R9: While idle, `pwr_en` follows the power mask register.
- R10: Each count is sampled when its phase begins. A count written during a cycle is used the next time its phase starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| host_pull | output | 1 | 1 = drive the open-drain host line low |
| pwr_en | output | 8 | Per-domain power enables |
| rx_window | output | 1 | Receive window open |
| cfg_err | output | 1 | Enable refused because a count is zero |

## Verification
The hardest situations to reach from the ports are an abort that lands in the middle of a long settle phase and recovery from a refused enable. Both need the cycle to be in one exact phase when the control write arrives. The stimulus waits on the port signature of the target phase, which is `host_pull` high while `pwr_en` equals the mask, and only then writes the control register. The reference model checks every clock that the block falls back to idle. Boundary timing at the 64× sleep unit and at the high bytes of the 16-bit counts is reached by building the block with a three-clock base unit.

// File: rtl/drx_pkg.sv
package drx_pkg;

    localparam int BYTE_W      = 8;
    localparam int CNT_W       = 16;
    localparam int ADDR_W      = 4;
    localparam int OFF_SEL_W   = 2;
    localparam int OFF_STEP_LG = 2;

    localparam logic [ADDR_W-1:0] A_PWR_MASK = 4'h0;
    localparam logic [ADDR_W-1:0] A_CONTROL  = 4'h1;
    localparam logic [ADDR_W-1:0] A_SLEEP_HI = 4'h6;
    localparam logic [ADDR_W-1:0] A_SLEEP_LO = 4'h7;
    localparam logic [ADDR_W-1:0] A_HOST     = 4'h8;
    localparam logic [ADDR_W-1:0] A_SETTLE_HI = 4'h9;
    localparam logic [ADDR_W-1:0] A_SETTLE_LO = 4'hA;
    localparam logic [ADDR_W-1:0] A_LISTEN   = 4'hB;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLEEP,
        ST_HOST,
        ST_SETTLE,
        ST_LISTEN
    } drx_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0]    pwr_mask;
        logic                 enable;
        logic [OFF_SEL_W-1:0] off_sel;
        logic [CNT_W-1:0]     sleep_cnt;
        logic [BYTE_W-1:0]    host_cnt;
        logic [CNT_W-1:0]     settle_cnt;
        logic [BYTE_W-1:0]    listen_cnt;
    } drx_cfg_t;

endpackage

// File: rtl/drx_cfg_regs.sv
module drx_cfg_regs
    import drx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output drx_cfg_t          cfg
);

    drx_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_addr)
                A_PWR_MASK:  cfg_d.pwr_mask = wr_data;
                A_CONTROL: begin
                    cfg_d.enable  = wr_data[0];
                    cfg_d.off_sel = wr_data[OFF_SEL_W:1];
                end
                A_SLEEP_HI:  cfg_d.sleep_cnt[CNT_W-1:BYTE_W]  = wr_data;
                A_SLEEP_LO:  cfg_d.sleep_cnt[BYTE_W-1:0]      = wr_data;
                A_HOST:      cfg_d.host_cnt                   = wr_data;
                A_SETTLE_HI: cfg_d.settle_cnt[CNT_W-1:BYTE_W] = wr_data;
                A_SETTLE_LO: cfg_d.settle_cnt[BYTE_W-1:0]     = wr_data;
                A_LISTEN:    cfg_d.listen_cnt                 = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    AST_HOST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_HOST) |=> (cfg_q.host_cnt == $past(wr_data))); // R2

endmodule

// File: rtl/drx_prescale.sv
module drx_prescale
    import drx_pkg::*;
#(
    parameter int unsigned BASE_DIV = 24000
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic [OFF_SEL_W-1:0] off_sel,
    output logic                 base_tick,
    output logic                 off_tick
);

    localparam int NUM_SEL = 1 << OFF_SEL_W;
    localparam int DIV_W   = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
    localparam int SUB_W   = OFF_STEP_LG * (NUM_SEL - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [SUB_W-1:0] sub;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [NUM_SEL-1:0] sel_tick;

    assign base_tick = (pre_q.div == DIV_W'(BASE_DIV - 1));

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        localparam logic [SUB_W-1:0] MASK = SUB_W'((1 << (i * OFF_STEP_LG)) - 1);
        assign sel_tick[i] = base_tick && ((pre_q.sub & MASK) == MASK);
    end

    assign off_tick = sel_tick[off_sel];

    always_comb begin
        pre_d = pre_q;
        if (restart) begin
            pre_d = '0;
        end else if (base_tick) begin
            pre_d.div = '0;
            pre_d.sub = pre_q.sub + SUB_W'(1);
        end else begin
            pre_d.div = pre_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    if (BASE_DIV > 1) begin : g_chk
        AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            restart |=> !base_tick); // R3
    end

endmodule

// File: rtl/drx_wake_seq.sv
module drx_wake_seq
    import drx_pkg::*;
#(
    parameter int unsigned BASE_DIV = 24000
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              host_pull,
    output logic [BYTE_W-1:0] pwr_en,
    output logic              rx_window,
    output logic              cfg_err
);

    typedef struct packed {
        drx_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             err;
    } seq_t;

    drx_cfg_t cfg;
    seq_t     seq_d, seq_q;
    logic     base_tick, off_tick, step, last, any_zero, restart;

    drx_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    drx_prescale #(.BASE_DIV(BASE_DIV)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .off_sel   (cfg.off_sel),
        .base_tick (base_tick),
        .off_tick  (off_tick)
    );

    assign step     = (seq_q.st == ST_SLEEP) ? off_tick : base_tick;
    assign last     = (seq_q.cnt <= CNT_W'(1));
    assign any_zero = (cfg.sleep_cnt == '0) || (cfg.host_cnt == '0) ||
                      (cfg.settle_cnt == '0) || (cfg.listen_cnt == '0);

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            ST_IDLE: begin
                if (cfg.enable && !seq_q.err) begin
                    if (any_zero) begin
                        seq_d.err = 1'b1;
                    end else begin
                        seq_d.st  = ST_SLEEP;
                        seq_d.cnt = cfg.sleep_cnt;
                    end
                end
            end
            ST_SLEEP: begin
                if (step) begin
                    if (last) begin
                        seq_d.st  = ST_HOST;
                        seq_d.cnt = CNT_W'(cfg.host_cnt);
                    end else begin
                        seq_d.cnt = seq_q.cnt - CNT_W'(1);
                    end
                end
            end
            ST_HOST: begin
                if (step) begin
                    if (last) begin
                        seq_d.st  = ST_SETTLE;
                        seq_d.cnt = cfg.settle_cnt;
                    end else begin
                        seq_d.cnt = seq_q.cnt - CNT_W'(1);
                    end
                end
            end
            ST_SETTLE: begin
                if (step) begin
                    if (last) begin
                        seq_d.st  = ST_LISTEN;
                        seq_d.cnt = CNT_W'(cfg.listen_cnt);
                    end else begin
                        seq_d.cnt = seq_q.cnt - CNT_W'(1);
                    end
                end
            end
            ST_LISTEN: begin
                if (step) begin
                    if (last) begin
                        seq_d.st  = ST_SLEEP;
                        seq_d.cnt = cfg.sleep_cnt;
                    end else begin
                        seq_d.cnt = seq_q.cnt - CNT_W'(1);
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
        if (!cfg.enable) begin
            seq_d.st  = ST_IDLE;
            seq_d.cnt = '0;
            seq_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, cnt: '0, err: 1'b0};
        else        seq_q <= seq_d;
    end

    assign restart   = (seq_d.st != seq_q.st) || (seq_q.st == ST_IDLE);
    assign host_pull = (seq_q.st == ST_HOST) || (seq_q.st == ST_SETTLE) ||
                       (seq_q.st == ST_LISTEN);
    assign pwr_en    = ((seq_q.st == ST_IDLE) || (seq_q.st == ST_SETTLE) ||
                        (seq_q.st == ST_LISTEN)) ? cfg.pwr_mask : '0;
    assign rx_window = (seq_q.st == ST_LISTEN);
    assign cfg_err   = seq_q.err;

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.enable |=> (seq_q.st == ST_IDLE)); // R8

    AST_ERR_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.err |=> (seq_q.st == ST_IDLE)); // R7

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_SLEEP && $past(seq_q.st) != ST_SLEEP) |->
        ($past(seq_q.st) == ST_IDLE || $past(seq_q.st) == ST_LISTEN)); // R3

    AST_HOST_AFTER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_HOST && $past(seq_q.st) != ST_HOST) |->
        ($past(seq_q.st) == ST_SLEEP)); // R4

    AST_LISTEN_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_LISTEN && $past(seq_q.st) != ST_LISTEN) |->
        ($past(seq_q.st) == ST_SETTLE)); // R6

endmodule

// File: tb/tb_drx_wake_seq.sv
`timescale 1ns/100ps
module tb_drx_wake_seq;

    localparam int DIV  = 3;
    localparam int MASK = 8'hA5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       host_pull, rx_window, cfg_err;
    logic [7:0] pwr_en;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    always #2.5 clk = ~clk;

    drx_wake_seq #(.BASE_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .host_pull(host_pull), .pwr_en(pwr_en),
        .rx_window(rx_window), .cfg_err(cfg_err)
    );

    // reference model: 0 idle, 1 sleep, 2 host, 3 settle, 4 listen
    int m_mask, m_en, m_sel, m_sleep, m_host, m_settle, m_listen;
    int m_st, m_rem, m_err;

    function automatic int nz(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mask = 0; m_en = 0; m_sel = 0; m_sleep = 0; m_host = 0;
            m_settle = 0; m_listen = 0; m_st = 0; m_rem = 0; m_err = 0;
        end else begin
            if (m_en == 0) begin
                m_st = 0; m_err = 0;
            end else if (m_st == 0) begin
                if (m_err == 0) begin
                    if (m_sleep == 0 || m_host == 0 || m_settle == 0 || m_listen == 0)
                        m_err = 1;
                    else begin
                        m_st = 1; m_rem = m_sleep * DIV * (1 << (2 * m_sel));
                    end
                end
            end else begin
                m_rem = m_rem - 1;
                if (m_rem == 0) begin
                    case (m_st)
                        1: begin m_st = 2; m_rem = nz(m_host) * DIV; end
                        2: begin m_st = 3; m_rem = nz(m_settle) * DIV; end
                        3: begin m_st = 4; m_rem = nz(m_listen) * DIV; end
                        default: begin m_st = 1; m_rem = nz(m_sleep) * DIV * (1 << (2 * m_sel)); end
                    endcase
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    4'h0: m_mask = int'(wr_data);
                    4'h1: begin m_en = int'(wr_data[0]); m_sel = int'(wr_data[2:1]); end
                    4'h6: m_sleep = (int'(wr_data) << 8) | (m_sleep & 255);
                    4'h7: m_sleep = (m_sleep & 65280) | int'(wr_data);
                    4'h8: m_host = int'(wr_data);
                    4'h9: m_settle = (int'(wr_data) << 8) | (m_settle & 255);
                    4'hA: m_settle = (m_settle & 65280) | int'(wr_data);
                    4'hB: m_listen = int'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && live && !done) begin
            int e_pwr, act, exp;
            string tag;
            e_pwr = (m_st == 0 || m_st == 3 || m_st == 4) ? m_mask : 0;
            exp = (((m_st >= 2) ? 1 : 0) << 10) | (((m_st == 4) ? 1 : 0) << 9) | (m_err << 8) | e_pwr;
            act = (int'(host_pull) << 10) | (int'(rx_window) << 9) | (int'(cfg_err) << 8) | int'(pwr_en);
            case (m_st)
                1: tag = "R3 sleep";
                2: tag = "R4 host";
                3: tag = "R5 settle";
                4: tag = "R6 listen";
                default: tag = (m_err != 0) ? "R7 error" : "R9 idle";
            endcase
            check(act == exp, tag, act, exp);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic bit cond(input int c);
        case (c)
            0: return (pwr_en == 8'h00) && !host_pull;
            1: return host_pull && (pwr_en == 8'h00);
            2: return host_pull && (pwr_en == 8'(MASK)) && !rx_window;
            3: return rx_window;
            default: return 1'b0;
        endcase
    endfunction

    task automatic meas(input int c, output int n);
        n = 0;
        while (!cond(c)) @(negedge clk);
        while (cond(c)) begin n++; @(negedge clk); end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(!host_pull && !rx_window && !cfg_err && pwr_en == 8'h00, "R1 reset outputs",
              {host_pull, rx_window, cfg_err, pwr_en}, 0);
        rst_n = 1'b1;
        live = 1'b1;
        @(negedge clk);
        check(pwr_en == 8'h00 && !host_pull, "R1 idle after reset", int'(pwr_en), 0);

        wr(4'h0, 8'(MASK));
        check(pwr_en == 8'(MASK), "R9 idle follows mask", int'(pwr_en), MASK);

        // enable with zero counts
        wr(4'h1, 8'h01);
        @(negedge clk);
        check(cfg_err == 1'b1, "R7 error raised", int'(cfg_err), 1);
        wr(4'h7, 8'h02); wr(4'h8, 8'h03); wr(4'hA, 8'h02); wr(4'hB, 8'h02);
        repeat (8) @(negedge clk);
        check(pwr_en == 8'(MASK) && !host_pull && cfg_err, "R7 stays idle", int'(pwr_en), MASK);
        wr(4'h1, 8'h00);
        @(negedge clk);
        check(cfg_err == 1'b0, "R7 error cleared", int'(cfg_err), 0);

        // normal cycle, sleep unit 4x
        wr(4'h1, 8'h03);
        meas(0, n); check(n == 24, "R3 sleep sel1", n, 24);
        meas(1, n); check(n == 9, "R4 host length", n, 9);
        meas(2, n); check(n == 6, "R5 settle length", n, 6);
        meas(3, n); check(n == 6, "R6 listen length", n, 6);
        meas(0, n); check(n == 24, "R6 back to sleep", n, 24);

        // mid-cycle update of listen and settle counts
        wr(4'hB, 8'h05);
        meas(3, n); check(n == 15, "R10 new listen count", n, 15);
        wr(4'h9, 8'h01); wr(4'hA, 8'h00);
        meas(2, n); check(n == 768, "R5 settle high byte", n, 768);

        // abort during settle
        while (!cond(2)) @(negedge clk);
        repeat (5) @(negedge clk);
        wr(4'h1, 8'h00);
        @(negedge clk);
        check(!host_pull && !rx_window && pwr_en == 8'(MASK), "R8 abort in settle",
              {host_pull, rx_window, pwr_en}, MASK);

        // 64x sleep unit
        wr(4'hA, 8'h01); wr(4'h9, 8'h00); wr(4'h7, 8'h01);
        wr(4'h1, 8'h07);
        meas(0, n); check(n == 192, "R3 sleep sel3", n, 192);

        // sleep high byte at address 0x6
        wr(4'h1, 8'h00);
        wr(4'h6, 8'h01); wr(4'h7, 8'h00);
        wr(4'h1, 8'h01);
        meas(0, n); check(n == 768, "R2 sleep high byte", n, 768);
        meas(1, n); check(n == 9, "R4 host again", n, 9);

        wr(4'h1, 8'h00);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule